// File: doc/BRIEF.md
# Flip Buffer Index Synchronizer

This block keeps track of which frame buffer a rendering engine is filling and which one the display side is scanning out. Three small index fields share one 32-bit surface word: a read index, a write index and a modulo count. Both indices wrap at the modulo count.

A command port carries methods from the command stream. These methods set any one of the three fields, advance the write index, or stall the stream until the reader has caught up. A register-write port lets the consumer overwrite the whole surface word, or advance the read index through a separate increment address. The surface word is always visible on a readback output.

When a stall command is accepted, the block emits a one-cycle flush pulse toward the surface logic. It then holds `cmd_ready` low and raises `stall_busy` for as long as the read and write indices differ.

Top module: `flip_sync`

## Requirements
- R1: During and after reset, before any stimulus, `surf_word` is 0, `cmd_ready` is 1, and `stall_busy` and `flush_pulse` are 0.
- R2: Field layout of the surface word: the write index is bits 22:20, the read index is bits 26:24 and the modulo is bits 30:28. Command codes on `cmd_op` are 0 no-op, 1 set-read, 2 set-write, 3 set-modulo, 4 advance-write and 5 stall; any other code behaves as a no-op. An accepted set command copies the 3-bit `cmd_param` into its own field only. The new word is visible the cycle after the clock edge.
- R3: An accepted advance-write command replaces the write index with (write + 1) mod modulo, using the modulo held before the edge. The write index may exceed the modulo; for example 7 with modulo 5 becomes 3.
- R4: A register write with `reg_sel` = 1 and `reg_wdata` bit 1 set replaces the read index with (read + 1) mod modulo. With bit 1 clear, such a write leaves the word unchanged.
- R5: A modulo field of 0 acts as 1, so either increment yields index 0.
- R6: In the cycle after a stall command is accepted, `flush_pulse` is high. It is low in any cycle that does not directly follow an accepted stall.
- R7: After a stall is accepted, `stall_busy` is 1 and `cmd_ready` is 0 while read differs from write. A command presented while `cmd_ready` is 0 has no effect on the word.
- R8: In the first cycle in which the read index equals the write index, `stall_busy` is 0 and `cmd_ready` is 1. No extra cycle of delay occurs. A stall issued while the indices already match never raises `stall_busy`.
- R9: A register write with `reg_sel` = 0 loads the entire 32-bit word. Bits outside the three fields are stored and read back unchanged.
- R10: An advance-read register write and an advance-write command in the same cycle both take effect.
- R11: A whole-word register write in the same cycle as an accepted command wins over the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code |
| cmd_param | input | 3 | Index value for set commands |
| cmd_ready | output | 1 | Command accepted this cycle when high |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = surface word, 1 = increment register |
| reg_wdata | input | 32 | Register write data |
| surf_word | output | 32 | Surface word readback |
| stall_busy | output | 1 | Stall waiting for reader |
| flush_pulse | output | 1 | One-cycle surface flush request |

## Verification
The assertions assume that `cmd_valid` and `reg_wr_en` are low while `rst` is high. Without this, a stall could not be attributed to the cycle before a flush. The no-effect check assumes that a refused command is not accompanied by a register write, because a register write legitimately changes the word even while commands are held off. The stimulus drives every input on the falling edge and clears all strobes during reset. It issues refused commands only in cycles with no register write; register writes during a stall use separate cycles.

// File: rtl/flip_sync_pkg.sv
package flip_sync_pkg;
    localparam int WORD_W  = 32;
    localparam int IDX_W   = 3;
    localparam int WR_LSB  = 20;
    localparam int RD_LSB  = 24;
    localparam int MOD_LSB = 28;
    localparam int OP_W    = 3;
    localparam int INC_RD_BIT = 1;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 3'd0,
        OP_SET_RD  = 3'd1,
        OP_SET_WR  = 3'd2,
        OP_SET_MOD = 3'd3,
        OP_INC_WR  = 3'd4,
        OP_STALL   = 3'd5
    } cmd_op_e;

    typedef struct packed {
        logic [IDX_W-1:0] rd;
        logic [IDX_W-1:0] wr;
        logic [IDX_W-1:0] md;
    } idx_set_t;

    typedef struct packed {
        logic set_rd;
        logic set_wr;
        logic set_md;
        logic inc_wr;
        logic stall;
    } cmd_dec_t;

    function automatic idx_set_t split_word(input logic [WORD_W-1:0] w);
        idx_set_t s;
        s.rd = w[RD_LSB  +: IDX_W];
        s.wr = w[WR_LSB  +: IDX_W];
        s.md = w[MOD_LSB +: IDX_W];
        return s;
    endfunction

    function automatic cmd_dec_t decode_cmd(input logic fire, input logic [OP_W-1:0] op);
        cmd_dec_t d;
        d = '0;
        if (fire) begin
            case (op)
                OP_SET_RD:  d.set_rd = 1'b1;
                OP_SET_WR:  d.set_wr = 1'b1;
                OP_SET_MOD: d.set_md = 1'b1;
                OP_INC_WR:  d.inc_wr = 1'b1;
                OP_STALL:   d.stall  = 1'b1;
                default:    d = '0;
            endcase
        end
        return d;
    endfunction
endpackage

// File: rtl/flip_wrap.sv
module flip_wrap #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] idx_i,
    input  logic [W-1:0] mod_i,
    output logic [W-1:0] idx_o
);
    logic [W-1:0] eff_mod;
    logic [W:0]   bumped;
    logic [W:0]   rem;

    always_comb begin
        eff_mod = (mod_i == '0) ? W'(1) : mod_i;
        bumped  = {1'b0, idx_i} + (W+1)'(1);
        rem     = bumped % {1'b0, eff_mod};
        idx_o   = rem[W-1:0];
    end

    // R3 / R5: wrapped result always below the effective modulo
    p_wrap_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        (idx_o < eff_mod) && ((mod_i == '0) -> (idx_o == '0)));
endmodule

// File: rtl/flip_stall_ctl.sv
module flip_stall_ctl #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stall_fire,
    input  logic [W-1:0] rd_i,
    input  logic [W-1:0] wr_i,
    output logic         busy_o,
    output logic         flush_o
);
    logic waiting_q;
    logic caught_up;

    assign caught_up = (rd_i == wr_i);
    assign busy_o    = waiting_q && !caught_up;

    always_ff @(posedge clk) begin
        if (rst) begin
            waiting_q <= 1'b0;
            flush_o   <= 1'b0;
        end else begin
            flush_o <= stall_fire;
            if (stall_fire)
                waiting_q <= 1'b1;
            else if (caught_up)
                waiting_q <= 1'b0;
        end
    end

    // R6: a flush pulse is always the echo of an accepted stall
    p_flush_follows_stall_r6: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> $past(stall_fire));

    // R8: busy only drops once the indices agree
    p_release_on_match_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (rd_i == wr_i));
endmodule

// File: rtl/flip_surface_reg.sv
module flip_surface_reg
    import flip_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_dec_t          dec,
    input  logic [IDX_W-1:0]  param,
    input  logic              inc_rd,
    input  logic [IDX_W-1:0]  rd_next,
    input  logic [IDX_W-1:0]  wr_next,
    input  logic              word_we,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] word_q
);
    logic [WORD_W-1:0] word_d;

    always_comb begin
        word_d = word_q;
        if (dec.set_md)
            word_d[MOD_LSB +: IDX_W] = param;
        if (dec.set_wr)
            word_d[WR_LSB +: IDX_W] = param;
        else if (dec.inc_wr)
            word_d[WR_LSB +: IDX_W] = wr_next;
        if (dec.set_rd)
            word_d[RD_LSB +: IDX_W] = param;
        else if (inc_rd)
            word_d[RD_LSB +: IDX_W] = rd_next;
        if (word_we)
            word_d = word_in;
    end

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else
            word_q <= word_d;
    end

    // R2: set-write lands in the write field when no word write collides
    p_set_write_r2: assert property (@(posedge clk) disable iff (rst)
        (dec.set_wr && !word_we) |=> (word_q[WR_LSB +: IDX_W] == $past(param)));

    // R9: whole-word write is taken verbatim
    p_word_write_r9: assert property (@(posedge clk) disable iff (rst)
        word_we |=> (word_q == $past(word_in)));
endmodule

// File: rtl/flip_sync.sv
module flip_sync
    import flip_sync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [IDX_W-1:0]  cmd_param,
    output logic              cmd_ready,
    input  logic              reg_wr_en,
    input  logic              reg_sel,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] surf_word,
    output logic              stall_busy,
    output logic              flush_pulse
);
    idx_set_t         cur;
    cmd_dec_t         dec;
    logic             fire;
    logic             inc_rd;
    logic             word_we;
    logic [IDX_W-1:0] rd_next;
    logic [IDX_W-1:0] wr_next;

    assign cur       = split_word(surf_word);
    assign cmd_ready = !stall_busy;
    assign fire      = cmd_valid && cmd_ready;
    assign dec       = decode_cmd(fire, cmd_op);
    assign word_we   = reg_wr_en && !reg_sel;
    assign inc_rd    = reg_wr_en && reg_sel && reg_wdata[INC_RD_BIT];

    flip_wrap #(.W(IDX_W)) u_wrap_rd (
        .clk(clk), .rst(rst), .idx_i(cur.rd), .mod_i(cur.md), .idx_o(rd_next)
    );

    flip_wrap #(.W(IDX_W)) u_wrap_wr (
        .clk(clk), .rst(rst), .idx_i(cur.wr), .mod_i(cur.md), .idx_o(wr_next)
    );

    flip_surface_reg u_surf (
        .clk(clk), .rst(rst), .dec(dec), .param(cmd_param),
        .inc_rd(inc_rd), .rd_next(rd_next), .wr_next(wr_next),
        .word_we(word_we), .word_in(reg_wdata), .word_q(surf_word)
    );

    flip_stall_ctl #(.W(IDX_W)) u_stall (
        .clk(clk), .rst(rst), .stall_fire(dec.stall),
        .rd_i(cur.rd), .wr_i(cur.wr),
        .busy_o(stall_busy), .flush_o(flush_pulse)
    );

    // R7: a refused command leaves the word alone
    p_ignored_while_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready && !reg_wr_en) |=> $stable(surf_word));
endmodule

// File: tb/flip_sync_test.sv
`timescale 1ns/1ps
module flip_sync_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [2:0]  cmd_param;
    logic        cmd_ready;
    logic        reg_wr_en;
    logic        reg_sel;
    logic [31:0] reg_wdata;
    logic [31:0] surf_word;
    logic        stall_busy;
    logic        flush_pulse;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flip_sync uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_param(cmd_param), .cmd_ready(cmd_ready), .reg_wr_en(reg_wr_en),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .surf_word(surf_word),
        .stall_busy(stall_busy), .flush_pulse(flush_pulse)
    );

    // kind: 0 command, 1 register write; sel is the op or reg_sel
    localparam int NV = 15;
    localparam logic        V_KIND [NV] = '{0,0,0,0,0,1,1,0,1,1,0,1,0,0,0};
    localparam logic [2:0]  V_SEL  [NV] = '{3,2,1,4,4,1,1,1,1,0,4,1,3,2,0};
    localparam logic [31:0] V_DATA [NV] = '{
        32'd5, 32'd3, 32'd2, 32'd0, 32'd0, 32'd2, 32'd1, 32'd7, 32'd2,
        32'h0A5F_00FF, 32'd0, 32'd2, 32'd6, 32'd1, 32'd0};
    localparam logic [31:0] V_EXP  [NV] = '{
        32'h5000_0000, 32'h5030_0000, 32'h5230_0000, 32'h5240_0000,
        32'h5200_0000, 32'h5300_0000, 32'h5300_0000, 32'h5700_0000,
        32'h5300_0000, 32'h0A5F_00FF, 32'h0A0F_00FF, 32'h080F_00FF,
        32'h680F_00FF, 32'h681F_00FF, 32'h681F_00FF};
    localparam string V_TAG [NV] = '{
        "R2", "R2", "R2", "R3", "R3", "R4", "R4", "R2",
        "R3", "R9", "R5", "R5", "R2", "R2", "R2"};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_param = 3'd0;
        reg_wr_en = 1'b0; reg_sel = 1'b0; reg_wdata = 32'd0;
    endtask

    // drive on the falling edge, sample 1 ns after the rising edge
    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [2:0] p);
        @(negedge clk);
        idle();
        cmd_valid = 1'b1; cmd_op = op; cmd_param = p;
        cycle();
        cmd_valid = 1'b0;
    endtask

    task automatic do_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        idle();
        reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
        cycle();
        reg_wr_en = 1'b0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 word in reset", surf_word, 32'h0);
        check("R1 ready in reset", {31'd0, cmd_ready}, 32'd1);
        @(negedge clk);
        rst = 1'b0;
        cycle();
        check("R1 word", surf_word, 32'h0);
        check("R1 busy", {31'd0, stall_busy}, 32'd0);
        check("R1 flush", {31'd0, flush_pulse}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            if (V_KIND[i] == 1'b0)
                do_cmd(V_SEL[i], V_DATA[i][2:0]);
            else
                do_reg(V_SEL[i][0], V_DATA[i]);
            check(V_TAG[i], surf_word, V_EXP[i]);
        end

        // stall: modulo 4, read 0, write 2
        do_reg(1'b0, 32'h4020_0000);
        do_cmd(3'd5, 3'd0);
        check("R6 flush after stall", {31'd0, flush_pulse}, 32'd1);
        check("R7 busy", {31'd0, stall_busy}, 32'd1);
        check("R7 ready low", {31'd0, cmd_ready}, 32'd0);
        do_cmd(3'd2, 3'd0);
        check("R6 flush one cycle", {31'd0, flush_pulse}, 32'd0);
        check("R7 command ignored", surf_word, 32'h4020_0000);
        do_reg(1'b1, 32'd2);
        check("R7 still busy", {31'd0, stall_busy}, 32'd1);
        do_reg(1'b1, 32'd2);
        check("R8 word matched", surf_word, 32'h4220_0000);
        check("R8 busy released", {31'd0, stall_busy}, 32'd0);
        check("R8 ready back", {31'd0, cmd_ready}, 32'd1);

        // same-cycle advance of both indices
        @(negedge clk);
        idle();
        cmd_valid = 1'b1; cmd_op = 3'd4;
        reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 32'd2;
        cycle();
        idle();
        check("R10 both advance", surf_word, 32'h4330_0000);

        // stall with indices already equal
        do_cmd(3'd5, 3'd0);
        check("R8 equal stall no busy", {31'd0, stall_busy}, 32'd0);
        check("R6 equal stall flush", {31'd0, flush_pulse}, 32'd1);

        // word write collides with a command
        @(negedge clk);
        idle();
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_param = 3'd1;
        reg_wr_en = 1'b1; reg_sel = 1'b0; reg_wdata = 32'h1234_5678;
        cycle();
        idle();
        check("R11 word write wins", surf_word, 32'h1234_5678);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule